// File: doc/BRIEF.md
# Two's-Complement Adder-Subtractor with Signed Overflow

This block is a purely combinational adder-subtractor for two operands of equal width held in two's-complement form. A single mode input picks the operation. At 0 the block adds the operands. At 1 it subtracts the second operand from the first. In subtract mode each bit of the second operand passes through an XOR with the mode bit, and the same mode bit enters the carry chain as its carry-in. Together these supply the missing +1 of the complement, so no separate incrementer is needed.

The carry chain is chosen at elaboration time. It can be a plain ripple chain, or a grouped lookahead in which each group forms its internal carries as two-level sum-of-products and passes one carry on to the next group. Both variants produce identical outputs. The block drives three outputs: the wrapped result, the unsigned carry out of the top bit, and a signed-overflow flag. The overflow flag is the XOR of the carry into the sign position and the carry out of it.

Top module: `addsub_core`

## Requirements
- R1: With `sub_i` = 0, `{carry_o, sum_o}` equals the unsigned sum `a_i + b_i` taken over WIDTH+1 bits.
- R2: With `sub_i` = 1, `sum_o` equals `(a_i - b_i) mod 2^WIDTH`, and `carry_o` is 1 exactly when `a_i >= b_i` read as unsigned numbers (that is, when no borrow occurs).
- R3: `ovf_o` is 1 exactly when the true signed result of the selected operation lies outside the range -2^(WIDTH-1) .. 2^(WIDTH-1)-1.
- R4: A carry out of the top bit does not by itself raise overflow. At WIDTH=4, adding 1001 (-7) and 0111 (7) gives sum 0000, carry 1, overflow 0. Adding 0101 (5) and 1101 (-3) gives sum 0010, carry 1, overflow 0.
- R5: Overflow can occur without a carry. At WIDTH=4, adding 0100 and 0100 gives sum 1000, carry 0, overflow 1.
- R6: Subtracting the most negative value (1000 at WIDTH=4) obeys the same overflow rule. 0000 - 1000 gives 1000 with carry 0 and overflow 1. 1111 - 1000 gives 0111 with carry 1 and overflow 0. 1000 - 1000 gives 0000 with carry 1 and overflow 0.
- R7: The ripple chain and the grouped lookahead chain give identical `sum_o`, `carry_o` and `ovf_o` for every input. This holds for any group size, including a group size that does not divide WIDTH.
- R8: `ovf_o` is 1 exactly when `a_i[WIDTH-1]` equals `b_i[WIDTH-1] ^ sub_i` and `sum_o[WIDTH-1]` differs from that shared sign.
- R9: When both operands and the mode are 0, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand (minuend in subtract mode) |
| b_i | input | WIDTH | Second operand (subtrahend in subtract mode) |
| sub_i | input | 1 | Mode: 0 add, 1 subtract |
| sum_o | output | WIDTH | Result modulo 2^WIDTH |
| carry_o | output | 1 | Carry out of the most significant bit |
| ovf_o | output | 1 | Signed overflow of the selected operation |

## Verification
The two flags can be raised by the same input. Carry and overflow are both set when two negative operands wrap into a non-negative result, for example 1000 + 1000, which gives 0000 with both flags high. Subtract mode adds a second coincidence: the mode bit inverts B and injects the carry-in in the same evaluation. When B is the most negative value, the inverted operand and the carry-in decide together whether the sign position overflows. Every operand pair is applied in both modes. Carry, overflow and result are judged against a sign-extended integer computation, and the ripple and lookahead builds must agree on every vector.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

  typedef enum logic {
    MODE_ADD = 1'b0,
    MODE_SUB = 1'b1
  } addsub_mode_e;

  typedef enum logic {
    CHAIN_RIPPLE    = 1'b0,
    CHAIN_LOOKAHEAD = 1'b1
  } chain_e;

  localparam int unsigned GROUP_DEF = 4;

endpackage

// File: rtl/addsub_b_cond.sv
// Conditional inversion of the second operand.
module addsub_b_cond #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] b_i,
  input  logic             inv_i,
  output logic [WIDTH-1:0] b_o
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_xor
    assign b_o[i] = b_i[i] ^ inv_i;
  end

endmodule

// File: rtl/addsub_bit_cell.sv
// One bit position: propagate/generate and sum.
module addsub_bit_cell (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic p_o,
  output logic g_o,
  output logic s_o
);

  assign p_o = a_i ^ b_i;
  assign g_o = a_i & b_i;
  assign s_o = p_o ^ c_i;

endmodule

// File: rtl/addsub_carry.sv
// Carry network, ripple or grouped lookahead.
module addsub_carry #(
  parameter int unsigned         WIDTH = 4,
  parameter addsub_pkg::chain_e  CHAIN = addsub_pkg::CHAIN_RIPPLE,
  parameter int unsigned         GROUP = addsub_pkg::GROUP_DEF
) (
  input  logic [WIDTH-1:0] p_i,
  input  logic [WIDTH-1:0] g_i,
  input  logic             cin_i,
  output logic [WIDTH:0]   c_o
);

  localparam int unsigned NGRP = (WIDTH + GROUP - 1) / GROUP;
  localparam int unsigned PADW = NGRP * GROUP;

  if (CHAIN == addsub_pkg::CHAIN_RIPPLE) begin : g_ripple
    assign c_o[0] = cin_i;
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign c_o[i+1] = g_i[i] | (p_i[i] & c_o[i]);
    end
  end else begin : g_look
    // Flat two-level carry into position j of a group.
    function automatic logic look_c(input logic [GROUP-1:0] p,
                                    input logic [GROUP-1:0] g,
                                    input logic             cin,
                                    input int unsigned      j);
      logic res;
      logic prod;
      res = 1'b0;
      for (int unsigned k = 0; k < GROUP; k++) begin
        if (k < j) begin
          prod = g[k];
          for (int unsigned m = 0; m < GROUP; m++) begin
            if (m > k && m < j) prod = prod & p[m];
          end
          res = res | prod;
        end
      end
      prod = cin;
      for (int unsigned m = 0; m < GROUP; m++) begin
        if (m < j) prod = prod & p[m];
      end
      return res | prod;
    endfunction

    logic [PADW-1:0] p_pad;
    logic [PADW-1:0] g_pad;
    logic [NGRP:0]   gc;

    if (PADW > WIDTH) begin : g_pad_fill
      assign p_pad = {{(PADW-WIDTH){1'b0}}, p_i};
      assign g_pad = {{(PADW-WIDTH){1'b0}}, g_i};
    end else begin : g_pad_none
      assign p_pad = p_i;
      assign g_pad = g_i;
    end

    assign gc[0]  = cin_i;
    assign c_o[0] = cin_i;

    for (genvar gi = 0; gi < NGRP; gi++) begin : g_grp
      localparam int unsigned LO  = gi * GROUP;
      localparam int unsigned HI  = (LO + GROUP > WIDTH) ? WIDTH : LO + GROUP;
      localparam int unsigned LEN = HI - LO;
      logic [GROUP-1:0] gp;
      logic [GROUP-1:0] gg;
      assign gp = p_pad[LO +: GROUP];
      assign gg = g_pad[LO +: GROUP];
      for (genvar j = 1; j <= LEN; j++) begin : g_pos
        assign c_o[LO+j] = look_c(gp, gg, gc[gi], j);
      end
      assign gc[gi+1] = look_c(gp, gg, gc[gi], LEN);
    end
  end

endmodule

// File: rtl/addsub_core.sv
module addsub_core #(
  parameter int unsigned        WIDTH = 4,
  parameter addsub_pkg::chain_e CHAIN = addsub_pkg::CHAIN_RIPPLE,
  parameter int unsigned        GROUP = addsub_pkg::GROUP_DEF
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o,
  output logic             ovf_o
);

  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH-1:0] p_w;
  logic [WIDTH-1:0] g_w;
  logic [WIDTH:0]   carry_w;

  addsub_b_cond #(.WIDTH(WIDTH)) i_b_cond (
    .b_i  (b_i),
    .inv_i(sub_i),
    .b_o  (b_eff)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    addsub_bit_cell i_cell (
      .a_i(a_i[i]),
      .b_i(b_eff[i]),
      .c_i(carry_w[i]),
      .p_o(p_w[i]),
      .g_o(g_w[i]),
      .s_o(sum_o[i])
    );
  end

  // Mode bit doubles as carry-in: supplies the +1 of the complement.
  addsub_carry #(.WIDTH(WIDTH), .CHAIN(CHAIN), .GROUP(GROUP)) i_carry (
    .p_i  (p_w),
    .g_i  (g_w),
    .cin_i(sub_i),
    .c_o  (carry_w)
  );

  assign carry_o = carry_w[WIDTH];
  assign ovf_o   = carry_w[MSB] ^ carry_w[WIDTH];

endmodule

// File: rtl/addsub_chk.sv
module addsub_chk #(
  parameter int unsigned WIDTH = 4
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             sub_i,
  input logic [WIDTH-1:0] sum_o,
  input logic             carry_o,
  input logic             ovf_o
);

  localparam int unsigned MSB = WIDTH - 1;

  logic signed [WIDTH+1:0] exact;
  logic        [WIDTH:0]   usum;
  logic                    known;
  logic                    sgn_b;

  always_comb begin
    known = !$isunknown({a_i, b_i, sub_i, sum_o, carry_o, ovf_o});
    exact = sub_i ? ($signed(a_i) - $signed(b_i)) : ($signed(a_i) + $signed(b_i));
    usum  = {1'b0, a_i} + {1'b0, b_i};
    sgn_b = b_i[MSB] ^ sub_i;
    if (known) begin
      if (!sub_i) begin
        p_add_r1: assert ({carry_o, sum_o} == usum)
          else $error("R1 add result mismatch");
      end else begin
        p_sub_r2: assert (sum_o == WIDTH'(a_i - b_i) && carry_o == (a_i >= b_i))
          else $error("R2 subtract result mismatch");
      end
      p_ovf_range_r3: assert (ovf_o == (exact != $signed(sum_o)))
        else $error("R3 overflow does not match signed range");
      p_ovf_sign_r8: assert (ovf_o == ((a_i[MSB] == sgn_b) && (sum_o[MSB] != a_i[MSB])))
        else $error("R8 overflow does not match sign rule");
      if (a_i == '0 && b_i == '0 && !sub_i) begin
        p_zero_r9: assert (sum_o == '0 && !carry_o && !ovf_o)
          else $error("R9 zero inputs gave nonzero outputs");
      end
    end
  end

endmodule

bind addsub_core addsub_chk #(.WIDTH(WIDTH)) i_addsub_chk (
  .a_i    (a_i),
  .b_i    (b_i),
  .sub_i  (sub_i),
  .sum_o  (sum_o),
  .carry_o(carry_o),
  .ovf_o  (ovf_o)
);

// File: tb/test_addsub_core.sv
`timescale 1ns/1ps
module test_addsub_core;

  localparam int unsigned W = 4;

  logic clk;
  logic [W-1:0] a, b;
  logic sub;
  logic [W-1:0] sum_r, sum_l;
  logic carry_r, carry_l, ovf_r, ovf_l;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  addsub_core #(.WIDTH(W), .CHAIN(addsub_pkg::CHAIN_RIPPLE)) i_addsub_core (
    .a_i(a), .b_i(b), .sub_i(sub),
    .sum_o(sum_r), .carry_o(carry_r), .ovf_o(ovf_r)
  );

  // Group size 3 leaves a partial group at width 4.
  addsub_core #(.WIDTH(W), .CHAIN(addsub_pkg::CHAIN_LOOKAHEAD), .GROUP(3)) i_addsub_core_la (
    .a_i(a), .b_i(b), .sub_i(sub),
    .sum_o(sum_l), .carry_o(carry_l), .ovf_o(ovf_l)
  );

  task automatic fail_line(input string tag, input string what, input int act, input int exp);
    fails++;
    $display("FAIL %s %s: actual %0d expected %0d (a=%b b=%b sub=%b)", tag, what, act, exp, a, b, sub);
  endtask

  // Drive at negedge, judge mid-cycle against an integer model.
  task automatic apply(input string tag, input logic [W-1:0] av, input logic [W-1:0] bv,
                       input logic sv);
    int sa, sb, res, ua, ub, exp_sum, exp_c, exp_v;
    @(negedge clk);
    a = av; b = bv; sub = sv;
    #2;
    vectors++;
    sa = int'($signed(av)); sb = int'($signed(bv));
    ua = int'(av); ub = int'(bv);
    res = sv ? sa - sb : sa + sb;
    exp_sum = res & ((1 << W) - 1);
    exp_c = sv ? int'(ua >= ub) : int'(ua + ub >= (1 << W));
    exp_v = int'(res > (1 << (W-1)) - 1 || res < -(1 << (W-1)));
    if (int'(sum_r) != exp_sum) fail_line(tag, "sum", int'(sum_r), exp_sum);
    if (int'(carry_r) != exp_c) fail_line(tag, "carry", int'(carry_r), exp_c);
    if (int'(ovf_r) != exp_v) fail_line("R3", "ovf", int'(ovf_r), exp_v);
    if ({sum_l, carry_l, ovf_l} != {sum_r, carry_r, ovf_r})
      fail_line("R7", "lookahead vs ripple", int'({sum_l, carry_l, ovf_l}),
                int'({sum_r, carry_r, ovf_r}));
  endtask

  task automatic expect_flags(input string tag, input logic [W-1:0] es, input logic ec,
                              input logic ev);
    vectors++;
    if ({sum_r, carry_r, ovf_r} != {es, ec, ev})
      fail_line(tag, "sum/carry/ovf", int'({sum_r, carry_r, ovf_r}), int'({es, ec, ev}));
  endtask

  task automatic t_zero_state;
    apply("R9", 4'b0000, 4'b0000, 1'b0);
    expect_flags("R9", 4'b0000, 1'b0, 1'b0);
  endtask

  task automatic t_all_add;
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++)
        apply("R1", W'(i), W'(j), 1'b0);
  endtask

  task automatic t_all_sub;
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++)
        apply("R2", W'(i), W'(j), 1'b1);
  endtask

  task automatic t_carry_no_ovf;
    apply("R4", 4'b1001, 4'b0111, 1'b0);
    expect_flags("R4", 4'b0000, 1'b1, 1'b0);
    apply("R4", 4'b0101, 4'b1101, 1'b0);
    expect_flags("R4", 4'b0010, 1'b1, 1'b0);
  endtask

  task automatic t_ovf_no_carry;
    apply("R5", 4'b0100, 4'b0100, 1'b0);
    expect_flags("R5", 4'b1000, 1'b0, 1'b1);
  endtask

  task automatic t_sub_most_neg;
    apply("R6", 4'b0000, 4'b1000, 1'b1);
    expect_flags("R6", 4'b1000, 1'b0, 1'b1);
    apply("R6", 4'b1111, 4'b1000, 1'b1);
    expect_flags("R6", 4'b0111, 1'b1, 1'b0);
    apply("R6", 4'b1000, 4'b1000, 1'b1);
    expect_flags("R6", 4'b0000, 1'b1, 1'b0);
  endtask

  task automatic t_both_flags;
    apply("R8", 4'b1000, 4'b1000, 1'b0);
    expect_flags("R8", 4'b0000, 1'b1, 1'b1);
    apply("R8", 4'b0111, 4'b1000, 1'b1);
    expect_flags("R8", 4'b1111, 1'b0, 1'b1);
  endtask

  initial begin
    a = '0; b = '0; sub = 1'b0;
    repeat (2) @(posedge clk);
    t_zero_state();
    t_all_add();
    t_all_sub();
    t_carry_no_ovf();
    t_ovf_no_carry();
    t_sub_most_neg();
    t_both_flags();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule